// File: doc/BRIEF.md
# Cascaded Serial Driver Chain Loader

This block sits on the host side of a string of cascaded 10-channel serial LED drivers. All drivers share one serial clock and one latch line. Each driver's serial output feeds the serial input of the next driver. A parallel frame holds one bit per channel of the whole string. The frame is accepted on a start request while the block is idle. It is then shifted out most-significant bit first on a data line. The shift clock is generated at a programmable fraction of the system clock.

When the last shift edge has been given, the block waits a hold interval and raises the shared latch line for a programmed width. All drivers update together on that one pulse. The block then reports completion with a one-cycle done flag. All spacing (clock phases, hold time, latch width) is counted in system clocks. Elaboration-time checks compare these counts against the nanosecond limits of the driver interface at the given system clock period.

Top module: `chain_loader`

## Requirements
- R1: Each accepted transfer produces exactly NUM_DEV×10 rising edges on `ser_clk_o`, followed by exactly one pulse on `ser_lat_o`.
- R2: Frame bit index d×10+c addresses channel c of device d, where device 0 is the one wired to the host. `frame_i[TOTAL_BITS-1]` is sent first and `frame_i[0]` last. After the latch, every device channel holds its own frame bit.
- R3: `ser_clk_o` is high for exactly HALF_DIV system clocks and low for exactly HALF_DIV system clocks between rising edges. The first rising edge comes HALF_DIV cycles after the start is accepted.
- R4: `ser_dat_o` changes only in the cycle where `ser_clk_o` falls, or when a transfer is accepted. It never changes while `ser_clk_o` is high or at its rising edge.
- R5: `ser_lat_o` rises HOLD_CYC cycles after the final falling edge of `ser_clk_o` and stays high for exactly LATCH_CYC cycles. `ser_clk_o` is low throughout.
- R6: `done_o` is high for exactly one cycle, the first cycle in which `ser_lat_o` is low again, i.e. 2×HALF_DIV×TOTAL_BITS+HOLD_CYC+LATCH_CYC cycles after the accepting edge. `busy_o` is high from the accepting edge through the done cycle.
- R7: A start request while `busy_o` is high is ignored. The running transfer keeps its captured frame and its edge count, and no extra transfer follows.
- R8: While reset is asserted, and after reset until the first start, all outputs are low.
- R9: A start held high across the end of a transfer is accepted in the first cycle `busy_o` is low. This leaves exactly one idle cycle between transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Transfer request, sampled only when idle |
| frame_i | input | TOTAL_BITS | Channel bits for the whole chain, captured on acceptance |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| ser_clk_o | output | 1 | Generated shift clock to all drivers |
| ser_dat_o | output | 1 | Serial data to the first driver |
| ser_lat_o | output | 1 | Shared latch pulse to all drivers |

## Verification
With the default parameters, the first shift edge appears HALF_DIV samples after the accepting edge. Each later edge follows 2×HALF_DIV samples after the one before. The latch rises HOLD_CYC samples after the last falling edge, and done arrives exactly 123 samples after acceptance. The bench samples every output at the falling system clock edge. It measures phase, hold and latch widths as run lengths counted sample by sample, then compares each with its parameter at the transition that ends it. Completion is awaited by polling done, and end-of-transfer checks are made on that sample and the following ones. Channel contents are judged from a behavioural model of the cascaded shift registers, clocked by the generated serial clock.

// File: rtl/chain_loader_pkg.sv
package chain_loader_pkg;

   localparam int unsigned CH_PER_DEV = 10;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_LOW   = 3'd1,
      ST_HIGH  = 3'd2,
      ST_HOLD  = 3'd3,
      ST_LATCH = 3'd4,
      ST_DONE  = 3'd5
   } ldr_state_t;

   function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                        input int unsigned c);
      int unsigned m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/chain_loader_pacer.sv
// Down-counting interval timer shared by every timed phase of a transfer.
module chain_loader_pacer #(
   parameter int unsigned CNT_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] val_i,
   output logic             expired_o
);

   logic [CNT_W-1:0] cnt_q;

   assign expired_o = (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= val_i;
      end else if (!expired_o) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   // A freshly loaded non-zero interval must not read as expired next cycle (R3)
   assert_load_not_expired_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i && val_i != '0) |=> !expired_o);

endmodule

// File: rtl/chain_loader_serializer.sv
// Parallel-load shift register; the top stage drives the serial line.
module chain_loader_serializer #(
   parameter int unsigned WIDTH = 30
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic             shift_i,
   input  logic [WIDTH-1:0] frame_i,
   output logic             bit_o
);

   logic [WIDTH-1:0] stage_w;

   for (genvar g = 0; g < WIDTH; g++) begin : g_stage
      logic shin;
      logic bit_q;

      if (g == 0) begin : g_tail
         assign shin = 1'b0;
      end else begin : g_link
         assign shin = stage_w[g-1];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            bit_q <= 1'b0;
         end else if (load_i) begin
            bit_q <= frame_i[g];
         end else if (shift_i) begin
            bit_q <= shin;
         end
      end

      assign stage_w[g] = bit_q;
   end

   assign bit_o = stage_w[WIDTH-1];

   // Capture and advance come from different sequencer states (R2)
   assert_load_shift_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(load_i && shift_i));

   // Without a load or shift the serial line holds its value (R4)
   assert_hold_when_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && !shift_i) |=> $stable(bit_o));

endmodule

// File: rtl/chain_loader_seq.sv
// Transfer sequencer: idle, low/high shift phases, hold, latch, done.
module chain_loader_seq
   import chain_loader_pkg::*;
#(
   parameter int unsigned TOTAL_BITS = 30,
   parameter int unsigned HALF_DIV   = 2,
   parameter int unsigned HOLD_CYC   = 1,
   parameter int unsigned LATCH_CYC  = 2,
   parameter int unsigned TMR_W      = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             tmr_expired_i,
   output logic             tmr_load_o,
   output logic [TMR_W-1:0] tmr_val_o,
   output logic             ser_load_o,
   output logic             ser_shift_o,
   output logic             sclk_o,
   output logic             slat_o,
   output logic             busy_o,
   output logic             done_o
);

   localparam int unsigned BC_W = $clog2(TOTAL_BITS + 1);
   localparam logic [TMR_W-1:0] PHASE_LD = TMR_W'(HALF_DIV - 1);
   localparam logic [TMR_W-1:0] HOLD_LD  = TMR_W'(HOLD_CYC - 1);
   localparam logic [TMR_W-1:0] LATCH_LD = TMR_W'(LATCH_CYC - 1);
   localparam logic [BC_W-1:0]  ALL_BITS = BC_W'(TOTAL_BITS);
   localparam logic [BC_W-1:0]  ONE_BIT  = BC_W'(1);

   ldr_state_t      state_q, state_d;
   logic [BC_W-1:0] left_q, left_d;
   logic            sclk_q, slat_q, busy_q, done_q;

   always_comb begin
      state_d     = state_q;
      left_d      = left_q;
      tmr_load_o  = 1'b0;
      tmr_val_o   = PHASE_LD;
      ser_load_o  = 1'b0;
      ser_shift_o = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (start_i) begin
               state_d    = ST_LOW;
               ser_load_o = 1'b1;
               tmr_load_o = 1'b1;
               left_d     = ALL_BITS;
            end
         end
         ST_LOW: begin
            if (tmr_expired_i) begin
               state_d    = ST_HIGH;
               tmr_load_o = 1'b1;
            end
         end
         ST_HIGH: begin
            if (tmr_expired_i) begin
               left_d     = left_q - 1'b1;
               tmr_load_o = 1'b1;
               if (left_q == ONE_BIT) begin
                  state_d   = ST_HOLD;
                  tmr_val_o = HOLD_LD;
               end else begin
                  state_d     = ST_LOW;
                  ser_shift_o = 1'b1;
               end
            end
         end
         ST_HOLD: begin
            if (tmr_expired_i) begin
               state_d    = ST_LATCH;
               tmr_load_o = 1'b1;
               tmr_val_o  = LATCH_LD;
            end
         end
         ST_LATCH: begin
            if (tmr_expired_i) begin
               state_d = ST_DONE;
            end
         end
         default: begin
            state_d = ST_IDLE;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         left_q  <= '0;
         sclk_q  <= 1'b0;
         slat_q  <= 1'b0;
         busy_q  <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         left_q  <= left_d;
         sclk_q  <= (state_d == ST_HIGH);
         slat_q  <= (state_d == ST_LATCH);
         busy_q  <= (state_d != ST_IDLE);
         done_q  <= (state_d == ST_DONE);
      end
   end

   assign sclk_o = sclk_q;
   assign slat_o = slat_q;
   assign busy_o = busy_q;
   assign done_o = done_q;

   // Once running, busy only drops after the done cycle (R6, R7)
   assert_busy_until_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !done_o) |=> busy_o);

   // A start seen while running does not reload the frame (R7)
   assert_no_reload_when_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> !ser_load_o);

endmodule

// File: rtl/chain_loader.sv
// Host-side loader for a string of cascaded 10-channel serial drivers.
module chain_loader
   import chain_loader_pkg::*;
#(
   parameter  int unsigned NUM_DEV       = 3,
   parameter  int unsigned DEV_CH        = CH_PER_DEV,
   parameter  int unsigned HALF_DIV      = 2,
   parameter  int unsigned HOLD_CYC      = 1,
   parameter  int unsigned LATCH_CYC     = 2,
   parameter  int unsigned SYS_CLK_NS    = 20,
   parameter  int unsigned MIN_PHASE_NS  = 10,
   parameter  int unsigned MIN_PERIOD_NS = 34,
   parameter  int unsigned MIN_HOLD_NS   = 10,
   parameter  int unsigned MIN_LATCH_NS  = 20,
   localparam int unsigned TOTAL_BITS    = NUM_DEV * DEV_CH
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start_i,
   input  logic [TOTAL_BITS-1:0] frame_i,
   output logic                  busy_o,
   output logic                  done_o,
   output logic                  ser_clk_o,
   output logic                  ser_dat_o,
   output logic                  ser_lat_o
);

   localparam int unsigned TMR_MAX = max3(HALF_DIV, HOLD_CYC, LATCH_CYC);
   localparam int unsigned TMR_W   = $clog2(TMR_MAX + 1);
   localparam int unsigned BC_W    = $clog2(TOTAL_BITS + 1);
   localparam int unsigned RUN_W   = $clog2(HALF_DIV + 2);

   // ---------------- elaboration-time parameter checks ----------------
   if (NUM_DEV < 1 || DEV_CH < 1) begin : g_bad_size
      $error("chain_loader: chain must hold at least one channel");
   end
   if (HALF_DIV < 1 || HOLD_CYC < 1 || LATCH_CYC < 1) begin : g_bad_count
      $error("chain_loader: interval counts must be at least one cycle");
   end
   if (HALF_DIV * SYS_CLK_NS < MIN_PHASE_NS) begin : g_bad_phase
      $error("chain_loader: clock phase or data setup too short");
   end
   if (2 * HALF_DIV * SYS_CLK_NS < MIN_PERIOD_NS) begin : g_bad_period
      $error("chain_loader: serial clock too fast");
   end
   if (HOLD_CYC * SYS_CLK_NS < MIN_HOLD_NS) begin : g_bad_hold
      $error("chain_loader: latch too close to last clock edge");
   end
   if (LATCH_CYC * SYS_CLK_NS < MIN_LATCH_NS) begin : g_bad_latch
      $error("chain_loader: latch pulse too narrow");
   end

   logic             tmr_load, tmr_expired, ser_load, ser_shift;
   logic [TMR_W-1:0] tmr_val;

   chain_loader_seq #(
      .TOTAL_BITS (TOTAL_BITS),
      .HALF_DIV   (HALF_DIV),
      .HOLD_CYC   (HOLD_CYC),
      .LATCH_CYC  (LATCH_CYC),
      .TMR_W      (TMR_W)
   ) u_seq (
      .clk           (clk),
      .rst_n         (rst_n),
      .start_i       (start_i),
      .tmr_expired_i (tmr_expired),
      .tmr_load_o    (tmr_load),
      .tmr_val_o     (tmr_val),
      .ser_load_o    (ser_load),
      .ser_shift_o   (ser_shift),
      .sclk_o        (ser_clk_o),
      .slat_o        (ser_lat_o),
      .busy_o        (busy_o),
      .done_o        (done_o)
   );

   chain_loader_pacer #(
      .CNT_W (TMR_W)
   ) u_pacer (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (tmr_load),
      .val_i     (tmr_val),
      .expired_o (tmr_expired)
   );

   chain_loader_serializer #(
      .WIDTH (TOTAL_BITS)
   ) u_ser (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (ser_load),
      .shift_i (ser_shift),
      .frame_i (frame_i),
      .bit_o   (ser_dat_o)
   );

   // ---------------- port-level checkers ----------------
   logic             sclk_d, slat_d;
   logic [BC_W-1:0]  rise_cnt;
   logic [RUN_W-1:0] hi_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d   <= 1'b0;
         slat_d   <= 1'b0;
         rise_cnt <= '0;
         hi_run   <= '0;
      end else begin
         sclk_d <= ser_clk_o;
         slat_d <= ser_lat_o;
         if (!busy_o) begin
            rise_cnt <= '0;
         end else if (ser_clk_o && !sclk_d) begin
            rise_cnt <= rise_cnt + 1'b1;
         end
         if (!ser_clk_o) begin
            hi_run <= '0;
         end else if (hi_run != {RUN_W{1'b1}}) begin
            hi_run <= hi_run + 1'b1;
         end
      end
   end

   assert_edge_count_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (ser_lat_o && !slat_d) |-> (rise_cnt == BC_W'(TOTAL_BITS)));

   assert_high_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!ser_clk_o && sclk_d) |-> (hi_run == RUN_W'(HALF_DIV)));

   assert_data_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ser_clk_o |-> $stable(ser_dat_o));

   assert_latch_clk_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(ser_lat_o && ser_clk_o));

   assert_done_after_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!ser_lat_o && slat_d));

   assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

endmodule

// File: tb/tb_chain_loader.sv
module tb_chain_loader;

   localparam int NDEV = 3;
   localparam int TOT  = NDEV * 10;
   localparam int HD   = 2;
   localparam int HOLD = 1;
   localparam int LW   = 2;
   localparam int LAT  = 2 * HD * TOT + HOLD + LW;

   typedef struct packed {
      logic [TOT-1:0] frame;
      logic           first;
      logic           last;
   } vec_t;

   localparam vec_t VEC [6] = '{
      '{30'h0000_0001, 1'b0, 1'b1},
      '{30'h2000_0000, 1'b1, 1'b0},
      '{30'h3FFF_FFFF, 1'b1, 1'b1},
      '{30'h2AAA_AAAA, 1'b1, 1'b0},
      '{30'h1555_5555, 1'b0, 1'b1},
      '{30'h0ABC_1234, 1'b0, 1'b0}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [TOT-1:0] frame = '0;
   logic busy, done, sclk, sdat, slat;

   always #10 clk = ~clk;

   chain_loader #(
      .NUM_DEV (NDEV), .HALF_DIV (HD), .HOLD_CYC (HOLD), .LATCH_CYC (LW)
   ) dut (
      .clk (clk), .rst_n (rst_n), .start_i (start), .frame_i (frame),
      .busy_o (busy), .done_o (done), .ser_clk_o (sclk), .ser_dat_o (sdat),
      .ser_lat_o (slat)
   );

   int checks = 0;
   int fails  = 0;

   task automatic check(input bit ok, input string req, input logic [63:0] act,
                        input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // behavioural model of the cascaded driver shift registers and latches
   logic [TOT-1:0] chain   = '0;
   logic [TOT-1:0] latched = '0;
   always @(posedge sclk) chain <= {chain[TOT-2:0], sdat};

   // monitor, sampling away from the active edge
   int cyc = 0, t0 = 0, rises = 0, pulses = 0, done_cnt = 0, done_idx = 0;
   int hi_run = 0, lo_run = 0, lat_run = 0;
   int bad_phase = 0, bad_sdat = 0, bad_latch = 0;
   logic first_bit = 0, last_bit = 0;
   logic p_sclk = 0, p_sdat = 0, p_slat = 0, p_busy = 0;

   always @(negedge clk) begin
      cyc++;
      if (rst_n) begin
         if (busy && !p_busy) t0 = cyc;
         if (sclk && !p_sclk) begin
            rises++;
            if (lo_run != HD) bad_phase++;
            if (rises == 1) first_bit = sdat;
            last_bit = sdat;
         end
         if (!sclk && p_sclk && hi_run != HD) bad_phase++;
         if (sdat != p_sdat && p_busy && !(p_sclk && !sclk)) bad_sdat++;
         if (slat && !p_slat) begin
            pulses++;
            if (lo_run != HOLD) bad_latch++;
         end
         if (!slat && p_slat && (lat_run != LW || !done)) bad_latch++;
         if (slat && sclk) bad_latch++;
         if (slat) latched = chain;
         if (done) begin
            done_cnt++;
            done_idx = cyc - t0;
            if (!p_slat) bad_latch++;
         end
         hi_run  = sclk ? (p_sclk ? hi_run + 1 : 1) : 0;
         lo_run  = (!sclk && busy) ? ((p_sclk || !p_busy) ? 1 : lo_run + 1) : 0;
         lat_run = slat ? (p_slat ? lat_run + 1 : 1) : 0;
      end
      p_sclk = sclk; p_sdat = sdat; p_slat = slat; p_busy = busy;
   end

   task automatic clear_mon();
      rises = 0; pulses = 0; done_cnt = 0; done_idx = 0;
      bad_phase = 0; bad_sdat = 0; bad_latch = 0;
   endtask

   task automatic wait_done();
      bit seen;
      seen = 0;
      for (int i = 0; i < 2000 && !seen; i++) begin
         @(negedge clk); #1;
         if (done_cnt > 0) seen = 1;
      end
      check(seen, "R6 done timeout", 64'(seen), 64'd1);
   endtask

   task automatic check_xfer(input logic [TOT-1:0] exp, input string tag);
      check(latched == exp, {tag, " R2 channel contents"}, 64'(latched), 64'(exp));
      check(rises == TOT, {tag, " R1 edge count"}, 64'(rises), 64'(TOT));
      check(pulses == 1, {tag, " R1 latch pulses"}, 64'(pulses), 64'd1);
      check(bad_phase == 0, {tag, " R3 phase widths"}, 64'(bad_phase), 64'd0);
      check(bad_sdat == 0, {tag, " R4 data changes"}, 64'(bad_sdat), 64'd0);
      check(bad_latch == 0, {tag, " R5 latch timing"}, 64'(bad_latch), 64'd0);
      check(done_idx == LAT, {tag, " R6 done latency"}, 64'(done_idx), 64'(LAT));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      // R8: reset state
      repeat (3) @(negedge clk);
      check({sclk, sdat, slat, busy, done} == 5'b0, "R8 in reset",
            64'({sclk, sdat, slat, busy, done}), 64'd0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk); #1;
      check({sclk, sdat, slat, busy, done} == 5'b0, "R8 idle after reset",
            64'({sclk, sdat, slat, busy, done}), 64'd0);

      // table of frames and expected first/last serial bits
      foreach (VEC[k]) begin
         @(negedge clk); #1;
         clear_mon();
         frame = VEC[k].frame;
         start = 1'b1;
         @(negedge clk); #1;
         start = 1'b0;
         check(busy, "R6 busy after accept", 64'(busy), 64'd1);
         wait_done();
         check_xfer(VEC[k].frame, "table");
         check(first_bit == VEC[k].first, "R2 first bit sent", 64'(first_bit), 64'(VEC[k].first));
         check(last_bit == VEC[k].last, "R2 last bit sent", 64'(last_bit), 64'(VEC[k].last));
         check(done_cnt == 1, "R6 done pulses", 64'(done_cnt), 64'd1);
         @(negedge clk); #1;
         check(!busy && !done, "R6 idle after done", 64'({busy, done}), 64'd0);
      end

      // R7: start pulses while busy are ignored
      @(negedge clk); #1;
      clear_mon();
      frame = 30'h1234_5678;
      start = 1'b1;
      @(negedge clk); #1;
      start = 1'b0;
      repeat (20) @(negedge clk);
      #1;
      frame = 30'h3C3C_3C3C;
      start = 1'b1;
      repeat (3) @(negedge clk);
      #1;
      start = 1'b0;
      wait_done();
      check_xfer(30'h1234_5678, "R7 busy start");
      repeat (10) @(negedge clk);
      #1;
      check(!busy && pulses == 1, "R7 no extra transfer", 64'({busy, 8'(pulses)}), 64'd1);

      // R9: start held across the end of a transfer
      @(negedge clk); #1;
      clear_mon();
      frame = 30'h0F0F_0F0F;
      start = 1'b1;
      @(negedge clk); #1;
      frame = 30'h3333_0001;
      wait_done();
      check_xfer(30'h0F0F_0F0F, "R9 first");
      @(negedge clk); #1;
      check(!busy, "R9 one idle cycle", 64'(busy), 64'd0);
      clear_mon();
      @(negedge clk); #1;
      check(busy, "R9 held start accepted", 64'(busy), 64'd1);
      start = 1'b0;
      wait_done();
      check(latched == 30'h3333_0001, "R9 second frame", 64'(latched), 64'(30'h3333_0001));
      check(rises == TOT, "R9 R1 second edge count", 64'(rises), 64'(TOT));

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule